// File: doc/BRIEF.md
# Filter interrupt and status register

This block keeps the interrupt and status word of one digital filter unit that serves eight input channels. It holds two kinds of sticky flag for each channel: a short-circuit flag and a clock-absence flag. It also holds five sticky filter event flags (injected and regular end of conversion, injected and regular overrun, analog watchdog) and shows two live conversion-in-progress bits. One-cycle event pulses from the channels and from the filter set the flags. Software clears a flag by writing 1 to the matching bit of a clear word. A clear word uses the same bit positions as the status word.

Two channel qualifiers override software. A disabled channel has its short-circuit flag forced low. A disabled channel, or one whose receiver has not yet synchronised, has its clock-absence flag forced high. Seven interrupt enables pick which flags drive the single interrupt line. The line is registered, so it follows the flags by one cycle.

Top module: `fltr_irq_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, the status word reads 0x00FF_0000 when both busy inputs are low, and the interrupt output is 0.
- R2: The status word layout is: short-circuit flags of channels 7..0 in bits 31:24, clock-absence flags in bits 23:16, regular busy in bit 14, injected busy in bit 13, analog watchdog in bit 4, regular overrun in bit 3, injected overrun in bit 2, regular end of conversion in bit 1, injected end of conversion in bit 0. All other bits read 0. The filter event input `flt_evt` uses the same bit order as bits 4:0.
- R3: An event pulse sets its flag, and the flag is visible after the next clock edge. A flag stays set while no clear reaches it.
- R4: When `clr_we` is 1, each 1 in `clr_data` clears the flag at the same bit position after the next edge. Each 0 in `clr_data`, and any write with `clr_we` low, leaves the flags unchanged.
- R5: When a set event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: While `ch_enable[y]` is 0, short-circuit flag y reads 0 from the next edge on, and set events for it are ignored.
- R7: While `ch_enable[y]` or `ch_synced[y]` is 0, clock-absence flag y reads 1 from the next edge on, and clears for it are ignored.
- R8: Status bits 14 and 13 follow `reg_busy` and `inj_busy` in the same cycle, with no clock edge in between.
- R9: The bits of `irq_en` enable these sources: bit 0 injected end of conversion, bit 1 regular end of conversion, bit 2 injected overrun, bit 3 regular overrun, bit 4 analog watchdog, bit 5 any clock-absence flag, bit 6 any short-circuit flag. On each edge `irq` takes the OR of the enabled flags as they stood before that edge, so it rises one cycle after a flag becomes visible.
- R10: When `irq_en` was all zero at the previous edge, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_enable | input | 8 | Per-channel enable |
| ch_synced | input | 8 | Per-channel receiver synchronised |
| scd_evt | input | 8 | Short-circuit threshold reached, one pulse per event |
| ckab_evt | input | 8 | Channel clock loss detected, one pulse per event |
| flt_evt | input | 5 | Filter event pulses, in the bit order of status bits 4:0 |
| reg_busy | input | 1 | Regular conversion in progress, live |
| inj_busy | input | 1 | Injected conversion in progress, live |
| clr_we | input | 1 | Clear word valid this cycle |
| clr_data | input | 32 | Write-one-to-clear word, same positions as status |
| irq_en | input | 7 | Interrupt source enables |
| status | output | 32 | Status word |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that channel qualifiers dominate: short-circuit flags of disabled channels read low, and clock-absence flags of disabled or unsynchronised channels read high. They also check that a pulse always beats a same-cycle clear, that flags hold with no event and no clear, that a clear with no competing pulse takes effect, and that a fully masked interrupt stays low. The bench scenarios alone show the exact reset word, the field positions, the same-cycle response of the busy bits, and the one-cycle lag of the interrupt behind a flag. A random run compares the whole word and the interrupt against a model on every cycle.

// File: rtl/fisr_pkg.sv
package fisr_pkg;

    localparam int N_CH      = 8;
    localparam int N_FLT     = 5;
    localparam int STAT_W    = 32;
    localparam int SCD_LSB   = 24;
    localparam int CKAB_LSB  = 16;
    localparam int RBUSY_BIT = 14;
    localparam int JBUSY_BIT = 13;
    localparam int MID_W     = JBUSY_BIT - N_FLT;

    // interrupt sources, index = enable bit position
    typedef enum logic [2:0] {
        SRC_JEOC = 3'd0,
        SRC_REOC = 3'd1,
        SRC_JOVR = 3'd2,
        SRC_ROVR = 3'd3,
        SRC_AWD  = 3'd4,
        SRC_CKAB = 3'd5,
        SRC_SCD  = 3'd6
    } irq_src_e;

    localparam int N_SRC = int'(SRC_SCD) + 1;

    typedef struct packed {
        logic [N_CH-1:0]  scd;
        logic [N_CH-1:0]  ckab;
        logic             rsv_top;
        logic             rbusy;
        logic             jbusy;
        logic [MID_W-1:0] rsv_mid;
        logic [N_FLT-1:0] flt;
    } stat_word_t;

    localparam logic [STAT_W-1:0] STAT_RESET = 32'h00FF_0000;

    function automatic stat_word_t pack_status(
        input logic [N_CH-1:0]  scd,
        input logic [N_CH-1:0]  ckab,
        input logic             rbusy,
        input logic             jbusy,
        input logic [N_FLT-1:0] flt
    );
        stat_word_t w;
        w.scd     = scd;
        w.ckab    = ckab;
        w.rsv_top = 1'b0;
        w.rbusy   = rbusy;
        w.jbusy   = jbusy;
        w.rsv_mid = '0;
        w.flt     = flt;
        return w;
    endfunction

    function automatic logic [N_SRC-1:0] gather_sources(
        input logic [N_FLT-1:0] flt,
        input logic [N_CH-1:0]  ckab,
        input logic [N_CH-1:0]  scd
    );
        return {|scd, |ckab, flt};
    endfunction

endpackage

// File: rtl/fisr_sticky.sv
module fisr_sticky #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] frc_set_i,
    input  logic [W-1:0] frc_clr_i,
    output logic [W-1:0] flag_o
);

    logic [W-1:0] nxt;

    // priority per bit: forced low, forced high, event, clear, hold
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (frc_clr_i[i])      nxt[i] = 1'b0;
            else if (frc_set_i[i]) nxt[i] = 1'b1;
            else if (set_i[i])     nxt[i] = 1'b1;
            else if (clr_i[i])     nxt[i] = 1'b0;
            else                   nxt[i] = flag_o[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_o <= {W{RST_VAL}};
        else     flag_o <= nxt;
    end

endmodule

// File: rtl/fisr_irq_or.sv
module fisr_irq_or #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(src_i & en_i);
    end

endmodule

// File: rtl/fltr_irq_status.sv
module fltr_irq_status
    import fisr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   ch_enable,
    input  logic [N_CH-1:0]   ch_synced,
    input  logic [N_CH-1:0]   scd_evt,
    input  logic [N_CH-1:0]   ckab_evt,
    input  logic [N_FLT-1:0]  flt_evt,
    input  logic              reg_busy,
    input  logic              inj_busy,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    input  logic [N_SRC-1:0]  irq_en,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic [STAT_W-1:0] clr_mask;
    logic [N_CH-1:0]   scd_q, ckab_q, ckab_frc;
    logic [N_FLT-1:0]  flt_q;
    logic [N_SRC-1:0]  src;
    logic              unused_clr_bits;
    stat_word_t        word;

    assign clr_mask        = clr_we ? clr_data : '0;
    assign unused_clr_bits = ^clr_mask[CKAB_LSB-1:N_FLT];
    assign ckab_frc        = ~(ch_enable & ch_synced);

    fisr_sticky #(.W(N_CH), .RST_VAL(1'b0)) i_scd (
        .clk       (clk),
        .rst       (rst),
        .set_i     (scd_evt),
        .clr_i     (clr_mask[SCD_LSB +: N_CH]),
        .frc_set_i ('0),
        .frc_clr_i (~ch_enable),
        .flag_o    (scd_q)
    );

    fisr_sticky #(.W(N_CH), .RST_VAL(1'b1)) i_ckab (
        .clk       (clk),
        .rst       (rst),
        .set_i     (ckab_evt),
        .clr_i     (clr_mask[CKAB_LSB +: N_CH]),
        .frc_set_i (ckab_frc),
        .frc_clr_i ('0),
        .flag_o    (ckab_q)
    );

    fisr_sticky #(.W(N_FLT), .RST_VAL(1'b0)) i_flt (
        .clk       (clk),
        .rst       (rst),
        .set_i     (flt_evt),
        .clr_i     (clr_mask[N_FLT-1:0]),
        .frc_set_i ('0),
        .frc_clr_i ('0),
        .flag_o    (flt_q)
    );

    assign src = gather_sources(flt_q, ckab_q, scd_q);

    fisr_irq_or #(.N(N_SRC)) i_irq (
        .clk   (clk),
        .rst   (rst),
        .src_i (src),
        .en_i  (irq_en),
        .irq_o (irq)
    );

    assign word   = pack_status(scd_q, ckab_q, reg_busy, inj_busy, flt_q);
    assign status = word;

endmodule

// File: rtl/fisr_checks.sv
module fisr_checks
    import fisr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_CH-1:0]   ch_enable,
    input logic [N_CH-1:0]   ch_synced,
    input logic [N_FLT-1:0]  flt_evt,
    input logic              clr_we,
    input logic [STAT_W-1:0] clr_data,
    input logic [N_SRC-1:0]  irq_en,
    input logic [STAT_W-1:0] status,
    input logic              irq
);

    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (flt_evt == '0 && !clr_we) |=> status[N_FLT-1:0] == $past(status[N_FLT-1:0]));

    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_we && (clr_data[N_FLT-1:0] & ~flt_evt) != '0)
        |=> (status[N_FLT-1:0] & $past(clr_data[N_FLT-1:0] & ~flt_evt)) == '0);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (flt_evt != '0) |=> (status[N_FLT-1:0] & $past(flt_evt)) == $past(flt_evt));

    assert_scd_forced_low_R6: assert property (@(posedge clk) disable iff (rst)
        (ch_enable != '1) |=> (status[SCD_LSB +: N_CH] & ~$past(ch_enable)) == '0);

    assert_ckab_held_R7: assert property (@(posedge clk) disable iff (rst)
        ((ch_enable & ch_synced) != '1)
        |=> (~status[CKAB_LSB +: N_CH] & ~$past(ch_enable & ch_synced)) == '0);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |=> !irq);

endmodule

bind fltr_irq_status fisr_checks i_fisr_checks (
    .clk       (clk),
    .rst       (rst),
    .ch_enable (ch_enable),
    .ch_synced (ch_synced),
    .flt_evt   (flt_evt),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .irq_en    (irq_en),
    .status    (status),
    .irq       (irq)
);

// File: tb/test_fltr_irq_status.sv
module test_fltr_irq_status;
    import fisr_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [N_CH-1:0]   ch_enable, ch_synced, scd_evt, ckab_evt;
    logic [N_FLT-1:0]  flt_evt;
    logic              reg_busy, inj_busy, clr_we;
    logic [STAT_W-1:0] clr_data;
    logic [N_SRC-1:0]  irq_en;
    logic [STAT_W-1:0] status;
    logic              irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // reference state
    logic [N_CH-1:0]  m_scd, m_ckab;
    logic [N_FLT-1:0] m_flt;
    logic             m_irq;

    always #5 clk = ~clk;

    fltr_irq_status i_fltr_irq_status (.*);

    function automatic logic [STAT_W-1:0] exp_word();
        return {m_scd, m_ckab, 1'b0, reg_busy, inj_busy, 8'h00, m_flt};
    endfunction

    task automatic model_step();
        logic [STAT_W-1:0] c;
        c = clr_we ? clr_data : '0;
        if (rst) begin
            m_scd = '0; m_ckab = '1; m_flt = '0; m_irq = 1'b0;
        end else begin
            m_irq  = |({|m_scd, |m_ckab, m_flt} & irq_en);
            m_flt  = flt_evt | (m_flt & ~c[4:0]);
            m_scd  = (scd_evt | (m_scd & ~c[31:24])) & ch_enable;
            m_ckab = ckab_evt | (m_ckab & ~c[23:16]) | ~(ch_enable & ch_synced);
        end
    endtask

    task automatic chk(input string req, input logic [STAT_W-1:0] act, input logic [STAT_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic cyc(input string req);
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        chk({req, " word"}, status, exp_word());
        chk({req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    task automatic idle();
        scd_evt = '0; ckab_evt = '0; flt_evt = '0; clr_we = 1'b0; clr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; ch_enable = '0; ch_synced = '0; reg_busy = 1'b0; inj_busy = 1'b0;
        irq_en = '0; idle();
        m_scd = '0; m_ckab = '1; m_flt = '0; m_irq = 1'b0;
        cyc("R1 in reset");
        chk("R1 reset word", status, 32'h00FF_0000);
        rst = 1'b0;
        cyc("R1 after reset");
        chk("R1 first word", status, 32'h00FF_0000);
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // R8 live busy bits, no edge in between
        reg_busy = 1'b1; #1;
        chk("R8 regular busy bit 14", status, 32'h00FF_4000);
        inj_busy = 1'b1; reg_busy = 1'b0; #1;
        chk("R8 injected busy bit 13", status, 32'h00FF_2000);
        inj_busy = 1'b0;

        // R7: clock-absence flags cleared once channels run, held otherwise
        ch_enable = '1; ch_synced = '1;
        clr_we = 1'b1; clr_data = 32'h00FF_0000;
        cyc("R4 clear ckab");
        chk("R4 ckab cleared", status, 32'h0000_0000);
        ch_enable[2] = 1'b0;
        cyc("R7 disable ch2");
        chk("R7 ckab held on disabled ch2", {24'b0, status[23:16]}, 32'h04);
        ch_synced[5] = 1'b0;
        cyc("R7 unsynced ch5");
        chk("R7 ckab held on unsynced ch5", {24'b0, status[23:16]}, 32'h24);
        ch_enable = '1; ch_synced = '1;
        cyc("R4 clear after release");
        chk("R4 ckab cleared after release", {24'b0, status[23:16]}, 32'h0);
        idle();

        // R6 short-circuit forced low while disabled
        scd_evt = 8'hFF;
        cyc("R3 scd set");
        chk("R3 scd all set", {24'b0, status[31:24]}, 32'hFF);
        scd_evt = 8'h08; ch_enable[3] = 1'b0;
        cyc("R6 disabled ch3");
        chk("R6 scd ch3 forced low", {24'b0, status[31:24]}, 32'hF7);
        ch_enable = '1; scd_evt = '0;
        cyc("R6 re-enabled");
        chk("R6 scd ch3 stays low", {24'b0, status[31:24]}, 32'hF7);

        // R2 field positions of filter flags
        flt_evt = 5'b10000;
        cyc("R2 watchdog bit 4");
        chk("R2 bit 4 set", {27'b0, status[4:0]}, 32'h10);
        flt_evt = '0; clr_we = 1'b1; clr_data = 32'hFFFF_FFFF;
        cyc("R4 clear all");
        chk("R4 all flags clear", status, 32'h0);

        // R5 set wins over same-cycle clear
        clr_we = 1'b1; clr_data = 32'h0000_0001; flt_evt = 5'b00001;
        cyc("R5 set and clear");
        chk("R5 injected eoc kept", {27'b0, status[4:0]}, 32'h01);
        idle(); clr_we = 1'b1; clr_data = 32'h0000_0001;
        cyc("R4 clear eoc");
        idle();

        // R9 interrupt lag, R10 masked
        irq_en = 7'b0000010; flt_evt = 5'b00010;
        cyc("R9 flag visible");
        chk("R9 flag set", {27'b0, status[4:0]}, 32'h02);
        chk("R9 irq not yet", {31'b0, irq}, 32'h0);
        flt_evt = '0;
        cyc("R9 irq rises");
        chk("R9 irq high", {31'b0, irq}, 32'h1);
        irq_en = '0;
        cyc("R10 masked");
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        // random phase, R3 R4 R5 R6 R7 R9 checked against the model
        for (int k = 0; k < 3000; k++) begin
            for (int y = 0; y < N_CH; y++) begin
                ch_enable[y] = ($urandom % 8) != 0;
                ch_synced[y] = ($urandom % 8) != 0;
                scd_evt[y]   = ($urandom % 10) == 0;
                ckab_evt[y]  = ($urandom % 10) == 0;
            end
            for (int f = 0; f < N_FLT; f++) flt_evt[f] = ($urandom % 6) == 0;
            reg_busy = $urandom % 2;
            inj_busy = $urandom % 2;
            clr_we   = ($urandom % 4) == 0;
            clr_data = $urandom;
            if (($urandom % 16) == 0) irq_en = N_SRC'($urandom);
            cyc("R3/R4/R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule